// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block sits behind a management register port that addresses 32 registers of 16 bits each at a single PHY address. It turns a handful of those registers into a window onto a much larger internal register space. Every internal register there is named by an 8-bit page and an 8-bit offset, and holds up to 64 bits. The serial management framing and the contents of the internal registers are outside the block.

To use the window, the host first selects a page and fills the four 16-bit data slices if it wants a write. It then writes the offset together with a read or write command bit. The bridge raises a request on its backend port and holds it until the backend acknowledges. At that point the command bits clear by themselves. For a read, the returned 64-bit value lands in the data slices at the same moment. The host polls the command register until both bits read zero.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset, every window register reads zero and `be_req` is low.
- R2: A write to register 0x10 with bit 0 set stores bits 15:8 as the page, and reading the register back returns {page, 7'b0, 1}. A write to 0x10 with bit 0 clear changes nothing.
- R3: Registers 0x18, 0x19, 0x1a and 0x1b hold data bits 15:0, 31:16, 47:32 and 63:48 respectively. Each one reads back what was last written to it.
- R4: A write to 0x11 with bit 0 set and bit 1 clear starts a backend write. From the next cycle on, `be_req` is high with `be_write`=1, and the backend port carries the stored page, the offset from bits 15:8, and the 64-bit data slices as they stood when the command was given.
- R5: A write to 0x11 with bit 1 set and bit 0 clear starts a backend read with `be_write`=0. On the edge where `be_ack` is seen, `be_rdata` is loaded into the data slices, and an 8-bit result appears in the low byte of 0x18.
- R6: While an operation is pending, register 0x11 reads {offset, 6'b0, rd, wr} with its command bit set. `be_req` and the backend fields stay steady until `be_ack`. On the edge where `be_ack` is seen, both command bits and `be_req` clear.
- R7: A write to 0x11 with both bits 0 and 1 set stores the offset but starts nothing: `be_req` stays low and both command bits read zero.
- R8: Writes to any register other than 0x10, 0x11 and 0x18 to 0x1b have no effect, and reads of those registers return zero.
- R9: While an operation is pending, writes to the page, address and data registers are ignored.
- R10: `be_ack` while no operation is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_we | input | 1 | Write strobe for the management register port |
| mgmt_reg | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Contents of the register named by `mgmt_reg` (combinational) |
| be_req | output | 1 | Backend request, held high until acknowledged |
| be_write | output | 1 | 1 for a backend write, 0 for a read |
| be_page | output | 8 | Backend page |
| be_offset | output | 8 | Backend register offset |
| be_wdata | output | 64 | Backend write data |
| be_rdata | input | 64 | Backend read data, valid with `be_ack` |
| be_ack | input | 1 | Backend acknowledge |

## Verification
A management write takes effect on the clock edge that samples it. Because `mgmt_rdata` is a combinational view of the register named by `mgmt_reg`, the bench reads it back on the following falling edge. `be_req` and its fields appear one edge after the command write. The command bits, `be_req` and a read result change on the edge that samples `be_ack`, so the bench checks them on the falling edge just after. While a request is pending, the bench re-checks the backend fields and the busy bits on every falling edge before it drives the acknowledge, even when the acknowledge comes after a random delay of zero to several cycles.

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge #(
  parameter logic [4:0] PAGE_REG  = 5'h10,
  parameter logic [4:0] ADDR_REG  = 5'h11,
  parameter logic [4:0] DATA_BASE = 5'h18,
  parameter int         DW        = 16,
  parameter int         NSLICE    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_we,
  input  logic [4:0]        mgmt_reg,
  input  logic [15:0]       mgmt_wdata,
  output logic [15:0]       mgmt_rdata,
  output logic              be_req,
  output logic              be_write,
  output logic [7:0]        be_page,
  output logic [7:0]        be_offset,
  output logic [63:0]       be_wdata,
  input  logic [63:0]       be_rdata,
  input  logic              be_ack
);
  localparam int BW = DW * NSLICE;

  logic [7:0]    page_q, offs_q;
  logic          page_en_q, cmd_wr_q, cmd_rd_q;
  logic [DW-1:0] slice_q [NSLICE];

  wire       busy    = cmd_wr_q | cmd_rd_q;
  wire       wr_ok   = mgmt_we && !busy;
  wire       is_page = (mgmt_reg == PAGE_REG);
  wire       is_addr = (mgmt_reg == ADDR_REG);
  wire [4:0] sl_off  = mgmt_reg - DATA_BASE;
  wire       is_data = (mgmt_reg >= DATA_BASE) && (int'(sl_off) < NSLICE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q    <= '0;
      page_en_q <= 1'b0;
      offs_q    <= '0;
      cmd_wr_q  <= 1'b0;
      cmd_rd_q  <= 1'b0;
    end else begin
      if (wr_ok && is_page && mgmt_wdata[0]) begin
        page_q    <= mgmt_wdata[15:8];
        page_en_q <= 1'b1;
      end
      if (wr_ok && is_addr) begin
        offs_q   <= mgmt_wdata[15:8];
        cmd_wr_q <= mgmt_wdata[0] & ~mgmt_wdata[1];
        cmd_rd_q <= mgmt_wdata[1] & ~mgmt_wdata[0];
      end else if (busy && be_ack) begin
        cmd_wr_q <= 1'b0;
        cmd_rd_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    always_ff @(posedge clk) begin
      if (!rst_n)
        slice_q[i] <= '0;
      else if (wr_ok && is_data && sl_off == 5'(i))
        slice_q[i] <= mgmt_wdata[DW-1:0];
      else if (cmd_rd_q && be_ack)
        slice_q[i] <= be_rdata[i*DW +: DW];
    end
    assign be_wdata[i*DW +: DW] = slice_q[i];
  end

  assign be_req    = busy;
  assign be_write  = cmd_wr_q;
  assign be_page   = page_q;
  assign be_offset = offs_q;

  always_comb begin
    mgmt_rdata = '0;
    if (is_page)      mgmt_rdata = {page_q, 7'b0, page_en_q};
    else if (is_addr) mgmt_rdata = {offs_q, 6'b0, cmd_rd_q, cmd_wr_q};
    else if (is_data) mgmt_rdata = slice_q[sl_off[$clog2(NSLICE)-1:0]];
  end

  // R6: request held with steady fields until acknowledged
  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_ack |=> be_req && $stable(be_write) && $stable(be_page)
                          && $stable(be_offset) && $stable(be_wdata));
  // R6: acknowledge ends the request
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack |=> !be_req);
  // R7: never both command bits at once
  p_cmd_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_rd_q, cmd_wr_q}));
  // R10: idle acknowledge does not start anything
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !be_req && be_ack && !(mgmt_we && is_addr) |=> !be_req);
  // R4: a request only starts from a command write
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !be_req && !(mgmt_we && is_addr) |=> !be_req);
  // R9: page register frozen while busy
  p_busy_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && mgmt_we && is_page |=> $stable(be_page));
endmodule

// File: tb/indirect_reg_bridge_tb.sv
module indirect_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_we = 1'b0;
  logic [4:0]  mgmt_reg = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        be_req, be_write;
  logic [7:0]  be_page, be_offset;
  logic [63:0] be_wdata;
  logic [63:0] be_rdata = '0;
  logic        be_ack = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  indirect_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .mgmt_we(mgmt_we), .mgmt_reg(mgmt_reg),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .be_req(be_req),
    .be_write(be_write), .be_page(be_page), .be_offset(be_offset),
    .be_wdata(be_wdata), .be_rdata(be_rdata), .be_ack(be_ack));

  logic [7:0]  m_page, m_offs;
  logic        m_en;
  logic [63:0] m_data;

  function automatic logic [15:0] exp_page(logic [7:0] p, logic en);
    return {p, 7'b0, en};
  endfunction
  function automatic logic [15:0] exp_addr(logic [7:0] o, logic rd, logic wr);
    return {o, 6'b0, rd, wr};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mwrite(logic [4:0] r, logic [15:0] d);
    @(negedge clk);
    mgmt_we = 1'b1; mgmt_reg = r; mgmt_wdata = d;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic mread(logic [4:0] r, output logic [15:0] d);
    mgmt_reg = r;
    #1 d = mgmt_rdata;
  endtask

  task automatic pulse_ack(logic [63:0] rd);
    be_ack = 1'b1; be_rdata = rd;
    @(negedge clk);
    be_ack = 1'b0;
  endtask

  task automatic check_slices(string req, logic [63:0] exp);
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      mread(5'h18 + 5'(i), v);
      check(req, {48'b0, v}, {48'b0, exp[i*16 +: 16]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    mread(5'h10, v); check("R1 page", {48'b0, v}, 64'h0);
    mread(5'h11, v); check("R1 addr", {48'b0, v}, 64'h0);
    check_slices("R1 data", 64'h0);
    check("R1 req", {63'b0, be_req}, 64'h0);

    // R2: enable bit clear ignored, then accepted
    mwrite(5'h10, 16'h7700);
    mread(5'h10, v); check("R2 no-enable", {48'b0, v}, 64'h0);
    mwrite(5'h10, 16'h3c01);
    mread(5'h10, v); check("R2 page", {48'b0, v}, {48'b0, exp_page(8'h3c, 1'b1)});
    m_page = 8'h3c; m_en = 1'b1;

    // R3: slice mapping
    m_data = 64'h0123_4567_89ab_cdef;
    for (int i = 0; i < 4; i++) mwrite(5'h18 + 5'(i), m_data[i*16 +: 16]);
    check_slices("R3 readback", m_data);
    check("R3 be_wdata", be_wdata, m_data);

    // R10: idle ack
    pulse_ack(64'hffff_ffff_ffff_ffff);
    check("R10 req", {63'b0, be_req}, 64'h0);
    check_slices("R10 data", m_data);

    // R7: both command bits
    mwrite(5'h11, 16'h5503);
    mread(5'h11, v); check("R7 addr", {48'b0, v}, {48'b0, exp_addr(8'h55, 1'b0, 1'b0)});
    check("R7 req", {63'b0, be_req}, 64'h0);

    // R8: unlisted registers
    mwrite(5'h12, 16'hbeef);
    mwrite(5'h1c, 16'hbeef);
    mread(5'h12, v); check("R8 0x12", {48'b0, v}, 64'h0);
    mread(5'h1c, v); check("R8 0x1c", {48'b0, v}, 64'h0);
    mread(5'h00, v); check("R8 0x00", {48'b0, v}, 64'h0);
    mread(5'h10, v); check("R8 page kept", {48'b0, v}, {48'b0, exp_page(m_page, m_en)});
    check_slices("R8 data kept", m_data);

    // Random operations
    for (int n = 0; n < 40; n++) begin
      logic is_rd;
      logic [63:0] rdv;
      int dly;
      m_page = 8'($urandom);
      m_offs = 8'($urandom);
      is_rd  = 1'($urandom);
      if (n == 0) m_page = 8'hff;
      mwrite(5'h10, {m_page, 8'($urandom) | 8'h01});
      if (!is_rd || n % 3 == 0) begin
        m_data = {$urandom, $urandom};
        for (int i = 0; i < 4; i++) mwrite(5'h18 + 5'(i), m_data[i*16 +: 16]);
      end
      mwrite(5'h11, {m_offs, 6'($urandom), is_rd, !is_rd});
      // R4 / R5: request fields
      check(is_rd ? "R5 req" : "R4 req", {63'b0, be_req}, 64'h1);
      check(is_rd ? "R5 dir" : "R4 dir", {63'b0, be_write}, {63'b0, !is_rd});
      check("R4 page", {56'b0, be_page}, {56'b0, m_page});
      check("R4 offset", {56'b0, be_offset}, {56'b0, m_offs});
      check("R4 wdata", be_wdata, m_data);
      mread(5'h11, v);
      check("R6 busy bits", {48'b0, v}, {48'b0, exp_addr(m_offs, is_rd, !is_rd)});
      // R9: writes while busy
      if (n % 2 == 0) begin
        mwrite(5'h10, 16'ha501);
        mwrite(5'h19, 16'h5a5a);
        mwrite(5'h11, 16'h0000);
        check("R9 page", {56'b0, be_page}, {56'b0, m_page});
        check("R9 wdata", be_wdata, m_data);
        check("R9 req", {63'b0, be_req}, 64'h1);
      end
      dly = int'($urandom % 5);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        check("R6 held", {63'b0, be_req}, 64'h1);
        check("R6 stable", be_wdata, m_data);
      end
      rdv = {$urandom, $urandom};
      pulse_ack(rdv);
      check("R6 cleared", {63'b0, be_req}, 64'h0);
      mread(5'h11, v);
      check("R6 idle bits", {48'b0, v}, {48'b0, exp_addr(m_offs, 1'b0, 1'b0)});
      if (is_rd) m_data = rdv;
      check_slices(is_rd ? "R5 result" : "R4 data kept", m_data);
      if (is_rd) begin
        mread(5'h18, v);
        check("R5 low byte", {56'b0, v[7:0]}, {56'b0, rdv[7:0]});
      end
    end
    finish_run();
  end
endmodule